// File: doc/BRIEF.md
# Three-Phase Gate PWM with Phase Gating

This block turns an 8-bit amplitude word into a fixed-frequency pulse-width signal and combines it with the per-phase commands of a six-step commutation sequencer. It produces the gate signals for a three-phase bridge. The system clock is divided by a programmable prescaler. Each divided tick advances an 8-bit ramp counter, and the counter is compared with the latched amplitude word. The latch only takes a new word when the ramp wraps, so a change of amplitude never cuts a pulse short or stretches one.

There are two output styles. In low-side chop mode the block drives six discrete enables. The high switch of each phase simply follows the phase's high command. The low switch follows the low command gated by the PWM. In half-bridge mode each phase has a single input line and a shutdown line, as used by integrated half-bridge drivers. The input carries the PWM while the phase is high and the inverted PWM while it is low. The duty is clamped above one half so that the high and low intervals stay asymmetric in the right direction. In both modes the phase's active-low float command switches the phase off for the whole float interval.

Top module: `phase_pwm_gater`

## Requirements
- R1: The ramp advances once every D clocks, where D is the prescale divisor (a value of 0 acts as 1). One PWM period is therefore 256·D clocks.
- R2: The PWM is high while the ramp value is below the latched word and low once the word is less than or equal to the ramp. Over one period it is high for exactly W·D clocks: word 0 gives no high time and word 255 gives 255·D clocks.
- R3: A new amplitude word (and the mode used for clamping) is taken only when the ramp wraps from 255 to 0. A pulse that is in progress keeps its original length.
- R4: With mode=0 (low-side chop), a phase with high=0 and float_n=1 has its low enable equal to the PWM.
- R5: With mode=0, a phase's high enable equals high AND float_n, with no PWM applied. Its low enable is 0 whenever high=1.
- R6: With mode=1 (half-bridge), a phase's input line carries the PWM when high=1 and the inverted PWM when high=0.
- R7: With mode=1, the latched word is raised to at least 129. A requested word below 129 therefore gives 129·D clocks of input-high per period for a high phase and 127·D clocks for a low phase. Mode 0 applies no clamp.
- R8: With mode=1, the active-low shutdown output of each phase equals that phase's float_n. With mode=0, all input and shutdown outputs are held at 0.
- R9: With mode=0, a phase with float_n=0 has both its high and its low enable off.
- R10: While reset is high, every gate enable and input line is 0 and every shutdown output is 0 (asserted). The latched word and the ramp restart from 0.
- R11: With mode=1, all six discrete enables are 0.
- R12: All outputs are registered. They reflect the phase, float and mode inputs one clock after those inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| volt_word | input | 8 | Requested amplitude word |
| prescale_div | input | 16 | Clocks per ramp step (0 acts as 1) |
| mode | input | 1 | 0 = low-side chop, 1 = half-bridge |
| ph_high | input | 3 | Per-phase command, 1 = high, 0 = low |
| ph_float_n | input | 3 | Per-phase float command, active low |
| hs_en | output | 3 | High-side switch enables |
| ls_en | output | 3 | Low-side switch enables |
| hb_in | output | 3 | Half-bridge driver input lines |
| hb_sd_n | output | 3 | Half-bridge shutdown, active low |

## Verification
On every cycle the assertions check the per-cycle mapping from phase commands, float and PWM to the registered outputs in both modes. They also check that the high and low enables of a phase are never on together, the reset levels, that the latched word holds between wraps, and that the clamp is applied when a half-bridge load occurs. Duty ratios over a whole period, the effect of the prescaler on period length, the clamp as seen at the outputs, and the rule that a pulse already in progress keeps its length across a word change all need many hundreds of cycles. The bench's directed scenarios show these by counting high clocks and pulse lengths at the ports.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

    localparam int RAMP_W_DEF  = 8;
    localparam int DIV_W_DEF   = 16;
    localparam int PHASES_DEF  = 3;

    typedef enum logic {
        DRV_LOW_CHOP = 1'b0,
        DRV_HALF_BR  = 1'b1
    } drive_mode_e;

    typedef struct packed {
        logic high;
        logic float_n;
    } phase_cmd_t;

    typedef struct packed {
        logic hs;
        logic ls;
        logic hb_in;
        logic hb_sd_n;
    } gate_out_t;

    localparam gate_out_t GATE_SAFE = '{hs: 1'b0, ls: 1'b0, hb_in: 1'b0, hb_sd_n: 1'b0};

    // Raise a word to a floor value when the clamp is enabled.
    function automatic logic [RAMP_W_DEF-1:0] floor_word(
        input logic [RAMP_W_DEF-1:0] w,
        input logic [RAMP_W_DEF-1:0] floor_val,
        input logic                  en
    );
        if (en && (w < floor_val)) return floor_val;
        return w;
    endfunction

    // Gate mapping for one phase, given the current PWM level.
    function automatic gate_out_t map_phase(
        input drive_mode_e m,
        input phase_cmd_t  c,
        input logic        pwm
    );
        gate_out_t g;
        g = GATE_SAFE;
        if (m == DRV_LOW_CHOP) begin
            g.hs = c.high & c.float_n;
            g.ls = ~c.high & c.float_n & pwm;
        end else begin
            g.hb_in   = c.high ? pwm : ~pwm;
            g.hb_sd_n = c.float_n;
        end
        return g;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (div == '0) ? '0 : div - 1'b1;
        tick  = (cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwm_ramp.sv
module pwm_ramp
    import pwm_gate_pkg::*;
#(
    parameter int RAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [RAMP_W-1:0] word_req,
    input  drive_mode_e       mode,
    output logic              pwm,
    output logic              wrap,
    output logic [RAMP_W-1:0] ramp,
    output logic [RAMP_W-1:0] active_word
);
    localparam logic [RAMP_W-1:0] RAMP_MAX = '1;
    localparam logic [RAMP_W-1:0] HALF_MIN = RAMP_W'((1 << (RAMP_W - 1)) + 1);

    logic [RAMP_W-1:0] next_word;

    always_comb begin
        wrap = tick && (ramp == RAMP_MAX);
        if (word_req < HALF_MIN && mode == DRV_HALF_BR) next_word = HALF_MIN;
        else                                            next_word = word_req;
        pwm  = (active_word > ramp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ramp        <= '0;
            active_word <= '0;
        end else if (tick) begin
            ramp <= ramp + 1'b1;
            if (wrap) active_word <= next_word;
        end
    end
endmodule

// File: rtl/phase_gate.sv
module phase_gate
    import pwm_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  drive_mode_e mode,
    input  phase_cmd_t  cmd,
    input  logic        pwm,
    output gate_out_t   gate
);
    always_ff @(posedge clk) begin
        if (rst) gate <= GATE_SAFE;
        else     gate <= map_phase(mode, cmd, pwm);
    end
endmodule

// File: rtl/phase_pwm_gater.sv
module phase_pwm_gater
    import pwm_gate_pkg::*;
#(
    parameter int NUM_PH = PHASES_DEF,
    parameter int RAMP_W = RAMP_W_DEF,
    parameter int DIV_W  = DIV_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RAMP_W-1:0] volt_word,
    input  logic [DIV_W-1:0]  prescale_div,
    input  logic              mode,
    input  logic [NUM_PH-1:0] ph_high,
    input  logic [NUM_PH-1:0] ph_float_n,
    output logic [NUM_PH-1:0] hs_en,
    output logic [NUM_PH-1:0] ls_en,
    output logic [NUM_PH-1:0] hb_in,
    output logic [NUM_PH-1:0] hb_sd_n
);
    drive_mode_e       mode_e;
    logic              tick;
    logic              pwm;
    logic              wrap;
    logic [RAMP_W-1:0] ramp;
    logic [RAMP_W-1:0] active_word;

    assign mode_e = drive_mode_e'(mode);

    pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk (clk),
        .rst (rst),
        .div (prescale_div),
        .tick(tick)
    );

    pwm_ramp #(.RAMP_W(RAMP_W)) u_ramp (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .word_req   (volt_word),
        .mode       (mode_e),
        .pwm        (pwm),
        .wrap       (wrap),
        .ramp       (ramp),
        .active_word(active_word)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        phase_cmd_t cmd;
        gate_out_t  gate;
        assign cmd.high    = ph_high[p];
        assign cmd.float_n = ph_float_n[p];

        phase_gate u_gate (
            .clk (clk),
            .rst (rst),
            .mode(mode_e),
            .cmd (cmd),
            .pwm (pwm),
            .gate(gate)
        );

        assign hs_en[p]   = gate.hs;
        assign ls_en[p]   = gate.ls;
        assign hb_in[p]   = gate.hb_in;
        assign hb_sd_n[p] = gate.hb_sd_n;
    end
endmodule

// File: rtl/phase_pwm_gater_sva.sv
module phase_pwm_gater_sva #(
    parameter int NUM_PH = 3,
    parameter int RAMP_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mode,
    input logic [NUM_PH-1:0] ph_high,
    input logic [NUM_PH-1:0] ph_float_n,
    input logic [NUM_PH-1:0] hs_en,
    input logic [NUM_PH-1:0] ls_en,
    input logic [NUM_PH-1:0] hb_in,
    input logic [NUM_PH-1:0] hb_sd_n,
    input logic              pwm,
    input logic              wrap,
    input logic [RAMP_W-1:0] active_word
);
    localparam logic [RAMP_W-1:0] HALF_MIN = RAMP_W'((1 << (RAMP_W - 1)) + 1);

    assert_reset_safe_R10: assert property (@(posedge clk)
        rst |=> (hs_en == '0 && ls_en == '0 && hb_in == '0 && hb_sd_n == '0));

    assert_no_shoot_through_R5: assert property (@(posedge clk) disable iff (rst)
        (hs_en & ls_en) == '0);

    assert_hold_word_R3: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(active_word));

    assert_clamp_load_R7: assert property (@(posedge clk) disable iff (rst)
        (wrap && mode) |=> (active_word >= HALF_MIN));

    assert_chop_high_R5: assert property (@(posedge clk) disable iff (rst)
        !mode |=> hs_en == ($past(ph_high) & $past(ph_float_n)));

    assert_chop_low_R4: assert property (@(posedge clk) disable iff (rst)
        !mode |=> ls_en == (~$past(ph_high) & $past(ph_float_n) & {NUM_PH{$past(pwm)}}));

    assert_chop_float_R9: assert property (@(posedge clk) disable iff (rst)
        !mode |=> ((hs_en | ls_en) & ~$past(ph_float_n)) == '0);

    assert_chop_hb_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !mode |=> (hb_in == '0 && hb_sd_n == '0));

    assert_half_input_R6: assert property (@(posedge clk) disable iff (rst)
        mode |=> hb_in == ~($past(ph_high) ^ {NUM_PH{$past(pwm)}}));

    assert_half_sd_R8: assert property (@(posedge clk) disable iff (rst)
        mode |=> hb_sd_n == $past(ph_float_n));

    assert_half_en_off_R11: assert property (@(posedge clk) disable iff (rst)
        mode |=> (hs_en == '0 && ls_en == '0));
endmodule

bind phase_pwm_gater phase_pwm_gater_sva #(.NUM_PH(NUM_PH), .RAMP_W(RAMP_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .ph_high    (ph_high),
    .ph_float_n (ph_float_n),
    .hs_en      (hs_en),
    .ls_en      (ls_en),
    .hb_in      (hb_in),
    .hb_sd_n    (hb_sd_n),
    .pwm        (pwm),
    .wrap       (wrap),
    .active_word(active_word)
);

// File: tb/test_phase_pwm_gater.sv
module test_phase_pwm_gater;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  volt_word = '0;
    logic [15:0] prescale_div = 16'd1;
    logic        mode = 1'b0;
    logic [2:0]  ph_high = '0;
    logic [2:0]  ph_float_n = '1;
    logic [2:0]  hs_en, ls_en, hb_in, hb_sd_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    phase_pwm_gater i_phase_pwm_gater (
        .clk(clk), .rst(rst), .volt_word(volt_word), .prescale_div(prescale_div),
        .mode(mode), .ph_high(ph_high), .ph_float_n(ph_float_n),
        .hs_en(hs_en), .ls_en(ls_en), .hb_in(hb_in), .hb_sd_n(hb_sd_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic logic pick(input int sel, input int idx);
        case (sel)
            0: return hs_en[idx];
            1: return ls_en[idx];
            2: return hb_in[idx];
            default: return hb_sd_n[idx];
        endcase
    endfunction

    // Count high samples of one output over n consecutive clocks.
    task automatic measure(input int sel, input int idx, input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pick(sel, idx)) cnt++;
        end
    endtask

    task automatic settle(input int div);
        int d;
        d = (div == 0) ? 1 : div;
        repeat (2 * 256 * d + 8) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        mode = 1'b1;
        @(negedge clk);
        check("R10 hs_en in reset", hs_en, 0);
        check("R10 ls_en in reset", ls_en, 0);
        check("R10 hb_in in reset", hb_in, 0);
        check("R10 hb_sd_n in reset", hb_sd_n, 0);
        rst = 1'b0;
        mode = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_chop(input logic [7:0] w);
        int c;
        mode = 1'b0; prescale_div = 16'd1; volt_word = w;
        ph_high = 3'b010; ph_float_n = 3'b011;
        settle(1);
        measure(1, 0, 256, c); check($sformatf("R2 R4 low-side duty w=%0d", w), c, w);
        measure(0, 1, 256, c); check("R5 high side unchopped", c, 256);
        measure(1, 1, 256, c); check("R5 low side off while high", c, 0);
        measure(0, 2, 256, c); check("R9 floated high enable", c, 0);
        measure(1, 2, 256, c); check("R9 floated low enable", c, 0);
        measure(2, 0, 256, c); check("R8 hb_in idle in chop", c, 0);
        measure(3, 0, 256, c); check("R8 hb_sd_n held in chop", c, 0);
    endtask

    task automatic t_prescale(input int div, input logic [7:0] w);
        int c, d;
        d = (div == 0) ? 1 : div;
        mode = 1'b0; prescale_div = 16'(div); volt_word = w;
        ph_high = 3'b000; ph_float_n = 3'b111;
        settle(div);
        measure(1, 0, 256 * d, c);
        check($sformatf("R1 period with divisor %0d", div), c, w * d);
    endtask

    task automatic t_half(input logic [7:0] w, input int exp_w);
        int c;
        mode = 1'b1; prescale_div = 16'd1; volt_word = w;
        ph_high = 3'b001; ph_float_n = 3'b111;
        settle(1);
        measure(2, 0, 256, c); check($sformatf("R6 R7 high-phase input w=%0d", w), c, exp_w);
        measure(2, 1, 256, c); check($sformatf("R6 R7 low-phase input w=%0d", w), c, 256 - exp_w);
        measure(0, 0, 256, c); check("R11 hs_en off in half-bridge", c, 0);
        measure(1, 1, 256, c); check("R11 ls_en off in half-bridge", c, 0);
    endtask

    task automatic t_half_float;
        int c;
        mode = 1'b1; prescale_div = 16'd1; volt_word = 8'd180;
        ph_high = 3'b011; ph_float_n = 3'b101;
        settle(1);
        measure(3, 1, 256, c); check("R8 floated phase shut down", c, 0);
        measure(3, 0, 256, c); check("R8 driven phase enabled", c, 256);
        @(negedge clk); ph_float_n = 3'b111;
        @(negedge clk); @(negedge clk);
        check("R12 R8 shutdown release one clock later", hb_sd_n, 3'b111);
    endtask

    task automatic t_reload;
        int run;
        logic prev;
        mode = 1'b0; prescale_div = 16'd1; volt_word = 8'd100;
        ph_high = 3'b000; ph_float_n = 3'b111;
        settle(1);
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (ls_en[0] && !prev) break;
            prev = ls_en[0];
        end
        run = 1;
        forever begin
            @(negedge clk);
            if (run == 5) volt_word = 8'd200;
            if (ls_en[0]) run++; else break;
        end
        check("R3 pulse in progress keeps length", run, 100);
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (ls_en[0] && !prev) break;
            prev = ls_en[0];
        end
        run = 1;
        forever begin
            @(negedge clk);
            if (ls_en[0]) run++; else break;
        end
        check("R3 next period uses new word", run, 200);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_chop(8'd77);
        t_chop(8'd0);
        t_chop(8'd255);
        t_prescale(4, 8'd50);
        t_prescale(0, 8'd30);
        t_half(8'd200, 200);
        t_half(8'd20, 129);
        t_chop(8'd20);
        t_half_float();
        t_reload();
        t_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule